// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port

This block is a general-purpose pin port that sits behind a simple word-addressed read/write bus. Software can drive up to 32 pins, set each one as an input or an output, and read their levels back. Each pin's level is also watched for a configured edge. A detected edge is held in a sticky capture register until software clears it. A per-pin mask then decides which held edges raise the interrupt line.

The top is built in one of three forms. In the bidirectional form each pin has a direction bit. The input-only form never drives a pin. The output-only form always drives every pin. The edge that is watched (rising, falling or either) is also fixed when the port is built. The default is a falling edge, which suits active-low event lines such as a touch-controller alert.

The bus is single-cycle. A strobe with the write flag set takes effect at that clock edge. A strobe without it returns data on the next cycle. Pin inputs pass through a two-flop synchronizer before anything uses them.

Top module: `mmio_pin_port`

## Requirements
- R1: After reset the output value, direction, mask and capture registers are all zero. `pin_oe`, `pin_out` and `irq` are 0, and reads of offsets 0 to 3 return 0.
- R2: A write to word offset 0 loads the output register. `pin_out` shows the written low `PIN_W` bits from the cycle after the write.
- R3: A write to offset 1 loads the direction register, where bit value 1 means output. `pin_oe` equals that register from the cycle after the write.
- R4: A read of offset 0 returns, per pin, the output register bit when the direction bit is 1. Otherwise it returns the synchronized pin level, which is the value `pin_in` held two clock edges earlier.
- R5: With the default falling-edge build, a 1-to-0 change of a synchronized pin level sets its bit in the capture register (offset 3) whatever the pin's direction. The bit stays set after the pin returns high. A rising change sets nothing.
- R6: Writing offset 3 clears each capture bit whose write-data bit is 1 and leaves bits written 0 unchanged. An edge detected in the same cycle as its clear keeps the bit set.
- R7: Offset 2 is a read/write interrupt mask with one bit per pin.
- R8: `irq` is 1 exactly when some bit is set in both the capture register and the mask.
- R9: Writes to offsets 4 to 7 change no register, and reads from them return 0.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. `bus_rdata` is 0 in every cycle not preceded by a read strobe.
- R11: An input-only build keeps `pin_oe` and `pin_out` at 0 and reads its direction register as 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, when strobed |
| bus_ofs | input | OFS_W | Word offset within the port window |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data, zero-extended |
| pin_in | input | PIN_W | Raw pin levels |
| pin_out | output | PIN_W | Value driven on pins whose enable is set |
| pin_oe | output | PIN_W | Per-pin output enable (tri-state control) |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check the following on every clock:
- a held capture bit that is not cleared stays set;
- a cleared bit drops unless an edge arrives in the same cycle, and such an edge always wins;
- `bus_rdata` is zero after idle cycles and after reads of the unused offsets;
- the enables follow a direction write;
- `irq` never rises with an empty mask.

Only the bench scenarios can show the remaining behaviour. These are the two-edge synchronizer delay on read-back, the mix of driven and sensed bits in a data read, and rising edges being ignored. They also cover the exact cycle where a clear meets a new edge, and the input-only build refusing to drive.

// File: rtl/mmio_pin_pkg.sv
package mmio_pin_pkg;

   typedef enum logic [1:0] {
      PORT_BIDIR    = 2'd0,
      PORT_IN_ONLY  = 2'd1,
      PORT_OUT_ONLY = 2'd2
   } port_kind_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2
   } edge_kind_e;

   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_DIR  = 1;
   localparam int unsigned OFS_MASK = 2;
   localparam int unsigned OFS_CAP  = 3;

endpackage

// File: rtl/mmio_pin_sync.sv
module mmio_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] level_q,
   output logic [WIDTH-1:0] level_prev_q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mmio_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
         level_prev_q <= '0;
      end else begin
         chain_q[0] <= raw_in;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         level_prev_q <= chain_q[STAGES-1];
      end
   end

   assign level_q = chain_q[STAGES-1];

endmodule

// File: rtl/mmio_pin_capture.sv
module mmio_pin_capture import mmio_pin_pkg::*; #(
   parameter int unsigned WIDTH = 8,
   parameter edge_kind_e  EDGE  = EDGE_FALL
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] level_prev,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] cap_q
);

   logic [WIDTH-1:0] edge_hit;

   if (EDGE == EDGE_RISE) begin : g_rise
      assign edge_hit = level & ~level_prev;
   end else if (EDGE == EDGE_FALL) begin : g_fall
      assign edge_hit = ~level & level_prev;
   end else begin : g_both
      assign edge_hit = level ^ level_prev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else        cap_q <= (cap_q & ~clr_mask) | edge_hit;
   end

   AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_q & ($past(cap_q) & ~$past(clr_mask))) == ($past(cap_q) & ~$past(clr_mask)));  // R5

   AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_q & $past(edge_hit)) == $past(edge_hit));  // R6

   AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_q & ($past(clr_mask) & ~$past(edge_hit))) == '0);  // R6

endmodule

// File: rtl/mmio_pin_port.sv
module mmio_pin_port import mmio_pin_pkg::*; #(
   parameter int unsigned PIN_W       = 8,
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned OFS_W       = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter port_kind_e  KIND        = PORT_BIDIR,
   parameter edge_kind_e  EDGE        = EDGE_FALL
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic [OFS_W-1:0] bus_ofs,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0] pin_in,
   output logic [PIN_W-1:0] pin_out,
   output logic [PIN_W-1:0] pin_oe,
   output logic             irq
);

   localparam bit HAS_IN  = (KIND != PORT_OUT_ONLY);
   localparam bit HAS_OUT = (KIND != PORT_IN_ONLY);
   localparam bit HAS_DIR = (KIND == PORT_BIDIR);

   if (PIN_W < 1 || PIN_W > 32 || PIN_W > BUS_W) begin : g_bad_width
      $error("mmio_pin_port: PIN_W must be 1..32 and not exceed BUS_W");
   end
   if (OFS_W < 2) begin : g_bad_ofs
      $error("mmio_pin_port: OFS_W must cover four registers");
   end

   // bus decode
   logic wr_hit, rd_hit;
   logic sel_data, sel_dir, sel_mask, sel_cap;
   logic [PIN_W-1:0] wr_bits;
   logic unused_wdata;

   assign wr_hit   = bus_sel &  bus_wr;
   assign rd_hit   = bus_sel & ~bus_wr;
   assign sel_data = (bus_ofs == OFS_W'(OFS_DATA));
   assign sel_dir  = (bus_ofs == OFS_W'(OFS_DIR));
   assign sel_mask = (bus_ofs == OFS_W'(OFS_MASK));
   assign sel_cap  = (bus_ofs == OFS_W'(OFS_CAP));
   assign wr_bits  = bus_wdata[PIN_W-1:0];
   assign unused_wdata = ^bus_wdata;

   logic [PIN_W-1:0] out_q, dir_q, mask_q, level, cap;

   // output value register
   if (HAS_OUT) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  out_q <= '0;
         else if (wr_hit && sel_data) out_q <= wr_bits;
      end
      AST_OUT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && sel_data) |=> (pin_out == $past(wr_bits)));  // R2
   end else begin : g_no_out
      assign out_q = '0;
   end

   // direction register
   if (HAS_DIR) begin : g_dir
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 dir_q <= '0;
         else if (wr_hit && sel_dir) dir_q <= wr_bits;
      end
      AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_hit && sel_dir) |=> (pin_oe == $past(wr_bits)));  // R3
   end else if (HAS_OUT) begin : g_dir_out
      assign dir_q = '1;
   end else begin : g_dir_in
      assign dir_q = '0;
   end

   // interrupt mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  mask_q <= '0;
      else if (wr_hit && sel_mask) mask_q <= wr_bits;
   end

   // input path: synchronizer and edge capture
   if (HAS_IN) begin : g_in
      logic [PIN_W-1:0] level_prev;
      logic [PIN_W-1:0] clr_mask;
      assign clr_mask = (wr_hit && sel_cap) ? wr_bits : '0;

      mmio_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
         .clk          (clk),
         .rst_n        (rst_n),
         .raw_in       (pin_in),
         .level_q      (level),
         .level_prev_q (level_prev)
      );

      mmio_pin_capture #(.WIDTH(PIN_W), .EDGE(EDGE)) u_cap (
         .clk        (clk),
         .rst_n      (rst_n),
         .level      (level),
         .level_prev (level_prev),
         .clr_mask   (clr_mask),
         .cap_q      (cap)
      );
   end else begin : g_no_in
      logic unused_pins;
      assign unused_pins = ^pin_in;
      assign level = '0;
      assign cap   = '0;
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;
   assign irq     = |(cap & mask_q);

   // read path
   logic [PIN_W-1:0] pin_view;
   logic [BUS_W-1:0] rd_word;
   logic [BUS_W-1:0] rdata_q;

   assign pin_view = (dir_q & out_q) | (~dir_q & level);

   always_comb begin
      rd_word = '0;
      if (sel_data)      rd_word = BUS_W'(pin_view);
      else if (sel_dir)  rd_word = BUS_W'(dir_q);
      else if (sel_mask) rd_word = BUS_W'(mask_q);
      else if (sel_cap)  rd_word = BUS_W'(cap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_hit ? rd_word : '0;
   end

   assign bus_rdata = rdata_q;

   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> (bus_rdata == '0));  // R10

   AST_RD_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && bus_ofs > OFS_W'(OFS_CAP)) |=> (bus_rdata == '0));  // R9

   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != '0));  // R8

endmodule

// File: tb/mmio_pin_port_test.sv
module mmio_pin_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [2:0]  ofs = '0;
   logic [31:0] wdata = '0;
   logic [7:0]  pins = '0;
   logic [31:0] rdata, rdata_in;
   logic [7:0]  pout, poe, pout_in, poe_in;
   logic        irq, irq_in;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   mmio_pin_port uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_ofs(ofs),
      .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins),
      .pin_out(pout), .pin_oe(poe), .irq(irq));

   mmio_pin_port #(.KIND(mmio_pin_pkg::PORT_IN_ONLY)) uut_in (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_ofs(ofs),
      .bus_wdata(wdata), .bus_rdata(rdata_in), .pin_in(pins),
      .pin_out(pout_in), .pin_oe(poe_in), .irq(irq_in));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference model, advanced on every rising edge
   logic [7:0]  m_out, m_dir, m_mask, m_cap;
   logic [31:0] m_rdata;
   logic [7:0]  hist [$];

   always @(posedge clk or negedge rst_n) begin : model
      logic [7:0] cur, prv, fall, clr;
      if (!rst_n) begin
         m_out = '0; m_dir = '0; m_mask = '0; m_cap = '0; m_rdata = '0;
         hist = '{8'h00, 8'h00, 8'h00};
      end else begin
         cur  = hist[1];
         prv  = hist[2];
         fall = prv & ~cur;
         m_rdata = '0;
         if (sel && !wr) begin
            case (ofs)
               3'd0: m_rdata = {24'h0, (m_dir & m_out) | (~m_dir & cur)};
               3'd1: m_rdata = {24'h0, m_dir};
               3'd2: m_rdata = {24'h0, m_mask};
               3'd3: m_rdata = {24'h0, m_cap};
               default: m_rdata = '0;
            endcase
         end
         clr = (sel && wr && ofs == 3'd3) ? wdata[7:0] : 8'h00;
         m_cap = (m_cap & ~clr) | fall;
         if (sel && wr && ofs == 3'd0) m_out  = wdata[7:0];
         if (sel && wr && ofs == 3'd1) m_dir  = wdata[7:0];
         if (sel && wr && ofs == 3'd2) m_mask = wdata[7:0];
         hist.push_front(pins);
         if (hist.size() > 3) void'(hist.pop_back());
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(poe == m_dir, "R3 pin_oe vs model", {24'h0, poe}, {24'h0, m_dir});
         chk(pout == m_out, "R2 pin_out vs model", {24'h0, pout}, {24'h0, m_out});
         chk(irq == |(m_cap & m_mask), "R8 irq vs model", {31'h0, irq}, {31'h0, |(m_cap & m_mask)});
         chk(rdata == m_rdata, "R10 bus_rdata vs model", rdata, m_rdata);
         chk(poe_in == 8'h00 && pout_in == 8'h00, "R11 input-only drives nothing",
             {16'h0, poe_in, pout_in}, 32'h0);
      end
   end

   task automatic bus_write(input logic [2:0] o, input logic [31:0] d);
      @(negedge clk); sel = 1'b1; wr = 1'b1; ofs = o; wdata = d;
      @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [2:0] o, output logic [31:0] d, output logic [31:0] d_in);
      @(negedge clk); sel = 1'b1; wr = 1'b0; ofs = o;
      @(negedge clk); sel = 1'b0; d = rdata; d_in = rdata_in;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, vi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(poe == 8'h00 && pout == 8'h00 && irq == 1'b0, "R1 outputs after reset",
          {15'h0, irq, poe, pout}, 32'h0);
      for (int i = 0; i < 4; i++) begin
         bus_read(3'(i), v, vi);
         chk(v == 32'h0, "R1 register reads zero after reset", v, 32'h0);
      end

      // R5 rising edges are not captured
      pins = 8'hFF; settle();
      bus_read(3'd3, v, vi);
      chk(v == 32'h0, "R5 rising edge ignored", v, 32'h0);

      // R2 R3 output and direction
      bus_write(3'd0, 32'hFFFF_FFA5);
      chk(pout == 8'hA5, "R2 pin_out after data write", {24'h0, pout}, 32'hA5);
      bus_write(3'd1, 32'h0000_000F);
      chk(poe == 8'h0F, "R3 pin_oe after direction write", {24'h0, poe}, 32'h0F);

      // R4 mixed read-back, R5 falling capture
      pins = 8'hF0; settle();
      bus_read(3'd0, v, vi);
      chk(v == 32'hF5, "R4 data read mixes driven and sensed bits", v, 32'hF5);
      bus_read(3'd3, v, vi);
      chk(v == 32'h0F, "R5 falling edges captured", v, 32'h0F);
      pins = 8'hFF; settle();
      bus_read(3'd3, v, vi);
      chk(v == 32'h0F, "R5 capture sticky after pin returns high", v, 32'h0F);

      // R7 mask, R8 irq
      bus_write(3'd2, 32'h0000_0003);
      chk(irq == 1'b1, "R8 irq with masked capture", {31'h0, irq}, 32'h1);
      bus_read(3'd2, v, vi);
      chk(v == 32'h03, "R7 mask read-back", v, 32'h03);

      // R6 write-one-to-clear
      bus_write(3'd3, 32'h0000_0001);
      bus_read(3'd3, v, vi);
      chk(v == 32'h0E, "R6 write one clears bit", v, 32'h0E);
      chk(irq == 1'b1, "R8 irq holds on remaining bit", {31'h0, irq}, 32'h1);
      bus_write(3'd3, 32'h0000_0000);
      bus_read(3'd3, v, vi);
      chk(v == 32'h0E, "R6 write zero leaves capture", v, 32'h0E);
      bus_write(3'd3, 32'h0000_0002);
      chk(irq == 1'b0, "R8 irq drops when no masked bit", {31'h0, irq}, 32'h0);

      // R6 edge in the same cycle as its clear wins (capture now 0x0C)
      @(negedge clk); pins = 8'hFB;
      @(negedge clk);
      @(negedge clk); sel = 1'b1; wr = 1'b1; ofs = 3'd3; wdata = 32'h0000_000C;
      @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
      bus_read(3'd3, v, vi);
      chk(v == 32'h04, "R6 coincident edge beats clear", v, 32'h04);
      pins = 8'hFF; settle();
      bus_write(3'd3, 32'h0000_00FF);

      // R9 holes in the window
      bus_write(3'd4, 32'hFFFF_FFFF);
      bus_write(3'd5, 32'hFFFF_FFFF);
      bus_write(3'd7, 32'hFFFF_FFFF);
      bus_read(3'd1, v, vi);
      chk(v == 32'h0F, "R9 direction unchanged by hole writes", v, 32'h0F);
      bus_read(3'd2, v, vi);
      chk(v == 32'h03, "R9 mask unchanged by hole writes", v, 32'h03);
      bus_read(3'd3, v, vi);
      chk(v == 32'h00, "R9 capture unchanged by hole writes", v, 32'h00);
      chk(pout == 8'hA5, "R9 pin_out unchanged by hole writes", {24'h0, pout}, 32'hA5);
      bus_read(3'd6, v, vi);
      chk(v == 32'h0, "R9 hole read returns zero", v, 32'h0);

      // R10 idle cycle returns zero
      @(negedge clk);
      chk(rdata == 32'h0, "R10 idle bus_rdata zero", rdata, 32'h0);

      // R11 input-only build
      bus_read(3'd1, v, vi);
      chk(vi == 32'h0, "R11 input-only direction reads zero", vi, 32'h0);
      bus_read(3'd0, v, vi);
      chk(vi == 32'hFF, "R11 input-only data reads pins", vi, 32'hFF);

      // R2 R4 second pattern
      bus_write(3'd0, 32'h0000_003C);
      chk(pout == 8'h3C, "R2 pin_out second pattern", {24'h0, pout}, 32'h3C);
      bus_read(3'd0, v, vi);
      chk(v == 32'hFC, "R4 data read second pattern", v, 32'hFC);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule